// File: doc/BRIEF.md
# Iterative Divisible-by-Three Detector

This block reports whether an unsigned N-bit operand is an exact multiple of three. It is purely combinational: the operand is fed through a ripple chain of identical remainder cells, one per operand bit, that perform binary long division by three starting at the most significant bit. Each cell keeps only the running remainder and hands it to its less-significant neighbour. The quotient is never formed.

The remainder leaving the least significant cell is brought out on a two-bit debug port, and a single flag is raised when that remainder is zero. A datapath uses the flag wherever a cheap divisibility test is needed and a wide modulo operator or lookup table would be too large. The width N is a parameter of at least 1.

Top module: `mod3_detect`

## Requirements
- R1: `is_mult3` is 1 exactly when the unsigned value of `din` is a multiple of three, and 0 otherwise.
- R2: `rem_out` equals the unsigned value of `din` modulo 3. It is encoded as plain binary: 2'd0, 2'd1 or 2'd2.
- R3: No remainder in the chain, and so neither `rem_out` nor any cell output, ever takes the code 2'd3.
- R4: An all-zero `din` gives `is_mult3` = 1 and `rem_out` = 2'd0.
- R5: Division runs from the most significant bit toward bit 0, and the remainder entering the top cell is 0. A lone set bit at position k therefore gives `rem_out` = 2^k mod 3: 1 for even k and 2 for odd k.
- R6: Each cell's output remainder is (2 × incoming remainder + input bit) mod 3 for incoming remainders 0, 1 and 2.
- R7: A cell that receives the unused remainder code 2'd3 outputs 2'd0 whatever its input bit is.
- R8: An all-ones operand is flagged divisible when N is even and gives remainder 1 when N is odd.
- R9: The outputs are combinational. They reflect a new `din` without any clock, and the block works for N = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | N | Unsigned operand under test |
| rem_out | output | 2 | Remainder of `din` divided by three (debug) |
| is_mult3 | output | 1 | High when `din` is a multiple of three |

## Verification
Every operand of a 10-bit instance is applied. This covers all remainder paths through the chain and separates a correct MSB-first order from a reversed one, because a reversed scan gives wrong remainders for odd-position bits. A 32-bit instance receives seeded random operands, together with single-bit walks, all-ones and all-zero values. These show whether long chains keep the remainder exact and whether the parity of N is handled. A 1-bit instance checks the degenerate chain. A standalone cell is driven with all eight input combinations, including the unused code 3, which the full chain can never produce.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int REM_W = 2;
  typedef logic [REM_W-1:0] rem_t;
  localparam rem_t REM_ZERO = 2'd0;
  localparam rem_t REM_ONE  = 2'd1;
  localparam rem_t REM_TWO  = 2'd2;
endpackage

// File: rtl/mod3_cell.sv
module mod3_cell
  import mod3_pkg::*;
(
  input  logic [1:0] rin,
  input  logic       bit_i,
  output logic [1:0] rout
);
  logic [2:0] partial;

  always_comb begin
    partial = {rin, bit_i};
    case (partial)
      3'd0: rout = REM_ZERO;
      3'd1: rout = REM_ONE;
      3'd2: rout = REM_TWO;
      3'd3: rout = REM_ZERO;
      3'd4: rout = REM_ONE;
      3'd5: rout = REM_TWO;
      default: rout = REM_ZERO;  // unused code 3 on rin
    endcase
  end

  always_comb begin
    if (!$isunknown({rin, bit_i})) begin
      assert_cell_range_R3: assert (rout != 2'd3)
        else $error("cell produced code 3");
      if (rin == 2'd3)
        assert_bad_code_R7: assert (rout == REM_ZERO)
          else $error("cell did not clear code 3");
    end
  end
endmodule

// File: rtl/mod3_chain.sv
module mod3_chain
  import mod3_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] din,
  output logic [1:0]   rem
);
  logic [N:0][1:0] link;

  assign link[N] = REM_ZERO;

  for (genvar i = N - 1; i >= 0; i--) begin : g_stage
    mod3_cell u_cell (
      .rin   (link[i+1]),
      .bit_i (din[i]),
      .rout  (link[i])
    );
  end

  assign rem = link[0];

  always_comb begin
    if (!$isunknown(din)) begin
      for (int k = 0; k <= N; k++) begin
        assert_link_range_R3: assert (link[k] != 2'd3)
          else $error("link %0d carries code 3", k);
      end
    end
  end
endmodule

// File: rtl/mod3_detect.sv
module mod3_detect
  import mod3_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] din,
  output logic [1:0]   rem_out,
  output logic         is_mult3
);
  logic [1:0] chain_rem;

  mod3_chain #(.N(N)) u_chain (
    .din (din),
    .rem (chain_rem)
  );

  assign rem_out  = chain_rem;
  assign is_mult3 = (chain_rem == REM_ZERO);

  always_comb begin
    if (!$isunknown(din)) begin
      assert_rem_match_R2: assert (64'(rem_out) == 64'(din) % 64'd3 || N > 64)
        else $error("remainder mismatch");
      assert_flag_match_R1: assert (is_mult3 == ((64'(din) % 64'd3) == 64'd0) || N > 64)
        else $error("flag mismatch");
    end
  end
endmodule

// File: tb/mod3_detect_tb.sv
module mod3_detect_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [9:0]  din10;
  logic [1:0]  rem10;
  logic        flag10;
  logic [31:0] din32;
  logic [1:0]  rem32;
  logic        flag32;
  logic [0:0]  din1;
  logic [1:0]  rem1;
  logic        flag1;
  logic [1:0]  c_rin;
  logic        c_bit;
  logic [1:0]  c_rout;

  mod3_detect #(.N(10)) u_dut      (.din(din10), .rem_out(rem10), .is_mult3(flag10));
  mod3_detect #(.N(32)) u_dut_wide (.din(din32), .rem_out(rem32), .is_mult3(flag32));
  mod3_detect #(.N(1))  u_dut_one  (.din(din1),  .rem_out(rem1),  .is_mult3(flag1));
  mod3_cell             u_cell     (.rin(c_rin), .bit_i(c_bit), .rout(c_rout));

  function automatic int exp_rem(input logic [63:0] v);
    return int'(v % 64'd3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic try32(input logic [31:0] v, input string req);
    din32 = v;
    @(negedge clk);
    check(req, int'(rem32), exp_rem(64'(v)));
    check(req, int'(flag32), int'(exp_rem(64'(v)) == 0));
    check("R3", int'(rem32 == 2'd3), 0);
  endtask

  initial begin
    din10 = '0; din32 = '0; din1 = '0; c_rin = '0; c_bit = 1'b0;
    void'($urandom(32'd2024));
    @(negedge clk);
    // R4: all-zero operand
    check("R4", int'(flag10), 1);
    check("R4", int'(rem10), 0);
    check("R4", int'(flag32), 1);

    // R1 R2 R3: exhaustive 10-bit sweep
    for (int v = 0; v < 1024; v++) begin
      din10 = 10'(v);
      #1;  // R9: combinational, settles without a clock edge
      check("R2", int'(rem10), v % 3);
      check("R1", int'(flag10), int'(v % 3 == 0));
      check("R3", int'(rem10 == 2'd3), 0);
    end

    // R5: single set bit walk, MSB-first order
    for (int k = 0; k < 32; k++) begin
      try32(32'd1 << k, "R5");
      check("R5", int'(rem32), (k % 2 == 0) ? 1 : 2);
    end

    // R8: all ones, even and odd width
    try32(32'hFFFF_FFFF, "R8");
    check("R8", int'(flag32), 1);
    din10 = 10'h3FF; #1;
    check("R8", int'(flag10), 1);
    din1 = 1'b1; #1;
    check("R8", int'(rem1), 1);
    check("R9", int'(flag1), 0);
    din1 = 1'b0; #1;
    check("R9", int'(flag1), 1);
    check("R4", int'(rem32 == 2'd3), 0);

    // R1 R2: seeded random 32-bit operands
    for (int n = 0; n < 2000; n++) try32($urandom(), "R2");
    try32(32'hFFFF_FFFE, "R1");
    try32(32'h8000_0001, "R1");

    // R6 R7: standalone cell, all eight combinations
    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 2; b++) begin
        c_rin = 2'(r); c_bit = b[0];
        #1;
        if (r == 3) check("R7", int'(c_rout), 0);
        else        check("R6", int'(c_rout), (2 * r + b) % 3);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule